// File: doc/BRIEF.md
# I2C Serial EEPROM Slave Controller

This block is the bus-facing half of a small byte-addressed nonvolatile memory (256 to 2048 bytes), with the storage array modelled as on-chip RAM. It watches a two-wire serial bus on synchronised and filtered clock and data lines. It answers a device-select byte whose top nibble is the fixed code 1010, and it drives only an open-drain pull-down enable for the data line. The three bits below that nibble extend the memory address above bit 7, so larger arrays need no second address byte.

Hosts can write one byte, or a burst that lands in a 16-byte page buffer. They can read at the internal pointer, load the pointer with a dummy write and then read, and stream any number of bytes. Nothing reaches the array until a STOP closes a write that carried data. The buffered page is then committed in one step, and the block goes deaf to the bus for a parameterised number of system clocks. Hosts detect the end of that interval by polling with the device-select byte until it is acknowledged. A write-protect input lets address bytes through but refuses data.

All pins are plain control and status signals: the bus carries its own per-bit handshake, so there is no stream interface at the block edge.

Top module: `eeprom_i2c_slave`

## Requirements
- R1: A START (SDA falling while SCL high) seen in any non-busy state restarts device-byte reception and releases SDA. A STOP (SDA rising while SCL high) ends the transfer. Buffered data followed by a repeated START instead of a STOP is discarded.
- R2: The block pulls SDA low during the ninth clock when a received device byte has bits 7..4 equal to 1010. A device byte with any other top nibble gets no acknowledge, and the block then ignores the bus until the next START.
- R3: In write mode, device-byte bits 3..1 supply address bits 10..8 (bits above the array size are ignored). The block acknowledges the following word-address byte (address bits 7..0) and every data byte.
- R4: After each data byte of a write, only the low 4 address bits increment. A burst of more than 16 bytes wraps inside the same page, and later bytes overwrite earlier ones.
- R5: The array changes only when a STOP follows a write that carried at least one accepted data byte. All buffered bytes of the page are committed together at that STOP.
- R6: For BUSY_CYCLES system clocks after a committing STOP, the block acknowledges nothing. Once the interval ends, a START plus device byte is acknowledged again, which allows ACK polling.
- R7: With wp_i high, the device and word-address bytes are acknowledged. The first data byte is not acknowledged, and the array is left unchanged.
- R8: The address pointer holds the last accessed address plus one. A read started without a preceding address write returns the byte at the pointer, wrapping from the top address to 0.
- R9: In read mode the block shifts out 8 bits MSB first and then releases SDA. A master ACK (SDA low on the ninth clock) makes it send the next address, incrementing across the full array and page boundaries. A NACK keeps SDA released until the next START or STOP.
- R10: A word-address write followed by a repeated START and a device byte with bit 0 = 1 returns the byte at the written address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired-AND level) |
| wp_i | input | 1 | Write protect, high blocks all data writes |
| sda_oe | output | 1 | Pull SDA low when 1, release when 0 |

## Verification
On every cycle, the assertions check four things. SDA is never pulled while the busy interval runs. The pull-down enable changes only while the filtered clock is low, except just after a bus condition. A START releases SDA. Commits, buffer writes and busy entry happen only after a STOP and never under write protect.

Only the bench scenarios can show the data-path results. These are the page wrap ordering, the pointer carry from the top address to 0, and sequential streaming. They also cover discarding a burst cut short by a repeated START, and the NACK-then-ACK pattern that a poller sees across the busy window.

// File: rtl/eei_pkg.sv
package eei_pkg;
  localparam logic [3:0] DEV_CODE = 4'b1010;
  localparam int unsigned PAGE_BYTES = 16;
  localparam int unsigned PAGE_W = $clog2(PAGE_BYTES);

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_DEV,
    ST_ADDR,
    ST_WDATA,
    ST_ACK,
    ST_RDATA,
    ST_RACK,
    ST_WAITSTOP,
    ST_BUSY
  } eei_state_e;
endpackage

// File: rtl/eei_line_filter.sv
module eei_line_filter #(
  parameter int unsigned FILT_LEN = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic line_i,
  output logic line_o
);
  localparam int unsigned CW = $clog2(FILT_LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] stab_q;
  logic          out_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b11;
      stab_q <= '0;
      out_q  <= 1'b1;
    end else begin
      sync_q <= {sync_q[0], line_i};
      if (sync_q[1] == out_q) begin
        stab_q <= '0;
      end else if (stab_q == CW'(FILT_LEN - 1)) begin
        out_q  <= sync_q[1];
        stab_q <= '0;
      end else begin
        stab_q <= stab_q + 1'b1;
      end
    end
  end

  assign line_o = out_q;
endmodule

// File: rtl/eei_bus_events.sv
module eei_bus_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_f,
  input  logic sda_f,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic scl_p, sda_p;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl_f;
      sda_p <= sda_f;
    end
  end

  assign scl_rise = scl_f & ~scl_p;
  assign scl_fall = ~scl_f & scl_p;
  assign start_ev = scl_f & scl_p & sda_p & ~sda_f;
  assign stop_ev  = scl_f & scl_p & ~sda_p & sda_f;
endmodule

// File: rtl/eei_store.sv
module eei_store
  import eei_pkg::*;
#(
  parameter int unsigned MEM_BYTES = 256,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              page_clear,
  input  logic              buf_wr,
  input  logic [PAGE_W-1:0] buf_idx,
  input  logic [7:0]        buf_data,
  input  logic              commit,
  input  logic [AW-1:0]     rd_addr,
  output logic [7:0]        rd_data
);
  logic [7:0]            mem_q [MEM_BYTES];
  logic [7:0]            pbuf_q [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] mask_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
    end else if (page_clear || commit) begin
      mask_q <= '0;
    end else if (buf_wr) begin
      mask_q[buf_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (buf_wr) pbuf_q[buf_idx] <= buf_data;
  end

  for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_commit
    always_ff @(posedge clk) begin
      if (commit && mask_q[g])
        mem_q[{rd_addr[AW-1:PAGE_W], PAGE_W'(g)}] <= pbuf_q[g];
    end
  end

  assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/eei_proto_fsm.sv
module eei_proto_fsm
  import eei_pkg::*;
#(
  parameter int unsigned MEM_BYTES   = 256,
  parameter int unsigned BUSY_CYCLES = 50000,
  localparam int unsigned AW = $clog2(MEM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sda_f,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic              wp_i,
  input  logic [7:0]        rd_data,
  output logic              sda_oe,
  output logic              page_clear,
  output logic              buf_wr,
  output logic [PAGE_W-1:0] buf_idx,
  output logic [7:0]        buf_data,
  output logic              commit,
  output logic [AW-1:0]     addr,
  output logic              busy
);
  localparam int unsigned BW = $clog2(BUSY_CYCLES + 1);

  eei_state_e    state_q, after_q;
  logic [3:0]    cnt_q;
  logic [7:0]    sh_q;
  logic [AW-1:0] addr_q;
  logic [2:0]    hi_q;
  logic          wrote_q, oe_q, mack_q;
  logic [BW-1:0] busy_cnt_q;
  logic [10:0]   full_addr;

  assign full_addr = {hi_q, sh_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      after_q    <= ST_IDLE;
      cnt_q      <= '0;
      sh_q       <= '0;
      addr_q     <= '0;
      hi_q       <= '0;
      wrote_q    <= 1'b0;
      oe_q       <= 1'b0;
      mack_q     <= 1'b0;
      busy_cnt_q <= '0;
      page_clear <= 1'b0;
      buf_wr     <= 1'b0;
      buf_idx    <= '0;
      buf_data   <= '0;
      commit     <= 1'b0;
    end else begin
      page_clear <= 1'b0;
      buf_wr     <= 1'b0;
      commit     <= 1'b0;
      if (state_q == ST_BUSY) begin
        if (busy_cnt_q == BW'(BUSY_CYCLES - 1)) state_q <= ST_IDLE;
        else busy_cnt_q <= busy_cnt_q + 1'b1;
      end else if (start_ev) begin
        state_q    <= ST_DEV;
        cnt_q      <= '0;
        oe_q       <= 1'b0;
        wrote_q    <= 1'b0;
        page_clear <= 1'b1;
      end else if (stop_ev) begin
        oe_q    <= 1'b0;
        cnt_q   <= '0;
        wrote_q <= 1'b0;
        if (wrote_q) begin
          commit     <= 1'b1;
          state_q    <= ST_BUSY;
          busy_cnt_q <= '0;
        end else begin
          state_q <= ST_IDLE;
        end
      end else begin
        unique case (state_q)
          ST_DEV, ST_ADDR, ST_WDATA: begin
            if (scl_rise) begin
              sh_q  <= {sh_q[6:0], sda_f};
              cnt_q <= cnt_q + 1'b1;
            end
            if (scl_fall && cnt_q == 4'd8) begin
              cnt_q <= '0;
              if (state_q == ST_DEV) begin
                if (sh_q[7:4] == DEV_CODE) begin
                  oe_q    <= 1'b1;
                  state_q <= ST_ACK;
                  if (sh_q[0]) begin
                    after_q <= ST_RDATA;
                  end else begin
                    after_q <= ST_ADDR;
                    hi_q    <= sh_q[3:1];
                  end
                end else begin
                  state_q <= ST_IDLE;
                end
              end else if (state_q == ST_ADDR) begin
                addr_q  <= full_addr[AW-1:0];
                oe_q    <= 1'b1;
                state_q <= ST_ACK;
                after_q <= ST_WDATA;
              end else if (wp_i) begin
                state_q <= ST_WAITSTOP;
              end else begin
                buf_wr              <= 1'b1;
                buf_idx             <= addr_q[PAGE_W-1:0];
                buf_data            <= sh_q;
                addr_q[PAGE_W-1:0]  <= addr_q[PAGE_W-1:0] + 1'b1;
                wrote_q             <= 1'b1;
                oe_q                <= 1'b1;
                state_q             <= ST_ACK;
                after_q             <= ST_WDATA;
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              state_q <= after_q;
              cnt_q   <= '0;
              if (after_q == ST_RDATA) begin
                sh_q   <= rd_data;
                oe_q   <= ~rd_data[7];
                addr_q <= addr_q + 1'b1;
              end else begin
                oe_q <= 1'b0;
              end
            end
          end
          ST_RDATA: begin
            if (scl_rise) cnt_q <= cnt_q + 1'b1;
            if (scl_fall) begin
              if (cnt_q == 4'd8) begin
                oe_q    <= 1'b0;
                state_q <= ST_RACK;
              end else begin
                sh_q <= {sh_q[6:0], 1'b0};
                oe_q <= ~sh_q[6];
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) mack_q <= ~sda_f;
            if (scl_fall) begin
              cnt_q <= '0;
              if (mack_q) begin
                sh_q    <= rd_data;
                oe_q    <= ~rd_data[7];
                addr_q  <= addr_q + 1'b1;
                state_q <= ST_RDATA;
              end else begin
                state_q <= ST_WAITSTOP;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe = oe_q;
  assign addr   = addr_q;
  assign busy   = (state_q == ST_BUSY);
endmodule

// File: rtl/eeprom_i2c_slave.sv
module eeprom_i2c_slave
  import eei_pkg::*;
#(
  parameter int unsigned MEM_BYTES   = 256,
  parameter int unsigned BUSY_CYCLES = 50000,
  parameter int unsigned FILT_LEN    = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  input  logic wp_i,
  output logic sda_oe
);
  localparam int unsigned AW = $clog2(MEM_BYTES);

  logic [1:0]        raw_lines, filt_lines;
  logic              scl_f, sda_f;
  logic              scl_rise, scl_fall, start_ev, stop_ev;
  logic              page_clear, buf_wr, commit, busy;
  logic [PAGE_W-1:0] buf_idx;
  logic [7:0]        buf_data, rd_data;
  logic [AW-1:0]     addr;

  assign raw_lines = {sda_i, scl_i};

  for (genvar g = 0; g < 2; g++) begin : g_filt
    eei_line_filter #(.FILT_LEN(FILT_LEN)) u_filt (
      .clk    (clk),
      .rst_n  (rst_n),
      .line_i (raw_lines[g]),
      .line_o (filt_lines[g])
    );
  end

  assign scl_f = filt_lines[0];
  assign sda_f = filt_lines[1];

  eei_bus_events u_events (
    .clk      (clk),
    .rst_n    (rst_n),
    .scl_f    (scl_f),
    .sda_f    (sda_f),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  eei_proto_fsm #(.MEM_BYTES(MEM_BYTES), .BUSY_CYCLES(BUSY_CYCLES)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .sda_f      (sda_f),
    .scl_rise   (scl_rise),
    .scl_fall   (scl_fall),
    .start_ev   (start_ev),
    .stop_ev    (stop_ev),
    .wp_i       (wp_i),
    .rd_data    (rd_data),
    .sda_oe     (sda_oe),
    .page_clear (page_clear),
    .buf_wr     (buf_wr),
    .buf_idx    (buf_idx),
    .buf_data   (buf_data),
    .commit     (commit),
    .addr       (addr),
    .busy       (busy)
  );

  eei_store #(.MEM_BYTES(MEM_BYTES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .page_clear (page_clear),
    .buf_wr     (buf_wr),
    .buf_idx    (buf_idx),
    .buf_data   (buf_data),
    .commit     (commit),
    .rd_addr    (addr),
    .rd_data    (rd_data)
  );
endmodule

// File: rtl/eei_checker.sv
module eei_checker (
  input logic clk,
  input logic rst_n,
  input logic sda_oe,
  input logic scl_f,
  input logic start_ev,
  input logic stop_ev,
  input logic busy,
  input logic commit,
  input logic buf_wr,
  input logic wp_i
);
  // R6
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R6
  busy_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(stop_ev));

  // R2
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_oe != $past(sda_oe)) |-> (!scl_f || $past(start_ev || stop_ev)));

  // R1
  start_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start_ev && !busy) |=> !sda_oe);

  // R5
  commit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit |-> $past(stop_ev));

  // R7
  wp_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    buf_wr |-> $past(!wp_i));
endmodule

bind eeprom_i2c_slave eei_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .sda_oe   (sda_oe),
  .scl_f    (scl_f),
  .start_ev (start_ev),
  .stop_ev  (stop_ev),
  .busy     (busy),
  .commit   (commit),
  .buf_wr   (buf_wr),
  .wp_i     (wp_i)
);

// File: tb/eeprom_i2c_slave_bench.sv
module eeprom_i2c_slave_bench;
  localparam int unsigned MEM_BYTES = 512;
  localparam int unsigned BUSY = 2000;
  localparam int unsigned Q = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_d = 1'b1;
  logic sda_d = 1'b1;
  logic wp = 1'b0;
  logic sda_oe;
  logic sda_line;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  assign sda_line = sda_d & ~sda_oe;

  eeprom_i2c_slave #(.MEM_BYTES(MEM_BYTES), .BUSY_CYCLES(BUSY), .FILT_LEN(3)) u_eeprom_i2c_slave (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_d),
    .sda_i  (sda_line),
    .wp_i   (wp),
    .sda_oe (sda_oe)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic q_wait(input int n);
    repeat (n * Q) @(negedge clk);
  endtask

  task automatic bus_start();
    sda_d = 1'b1; q_wait(1);
    scl_d = 1'b1; q_wait(1);
    sda_d = 1'b0; q_wait(1);
    scl_d = 1'b0; q_wait(1);
  endtask

  task automatic bus_stop();
    sda_d = 1'b0; q_wait(1);
    scl_d = 1'b1; q_wait(1);
    sda_d = 1'b1; q_wait(1);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      sda_d = b[i]; q_wait(1);
      scl_d = 1'b1; q_wait(2);
      scl_d = 1'b0;
    end
    sda_d = 1'b1; q_wait(1);
    scl_d = 1'b1; q_wait(1);
    acked = ~sda_line;
    q_wait(1);
    scl_d = 1'b0; q_wait(1);
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] d);
    sda_d = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      q_wait(1);
      scl_d = 1'b1; q_wait(1);
      d[i] = sda_line;
      q_wait(1);
      scl_d = 1'b0;
    end
    sda_d = mack ? 1'b0 : 1'b1; q_wait(1);
    scl_d = 1'b1; q_wait(2);
    scl_d = 1'b0;
    sda_d = 1'b1;
  endtask

  task automatic wait_busy();
    repeat (BUSY + 300) @(negedge clk);
  endtask

  task automatic write_bytes(input logic [8:0] a, input int n, input logic [7:0] base);
    bit ack;
    bus_start();
    send_byte({4'b1010, 2'b00, a[8], 1'b0}, ack); chk("R2 dev ack", ack, 1);
    send_byte(a[7:0], ack);                       chk("R3 word ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      send_byte(base + 8'(i), ack);               chk("R3 data ack", ack, 1);
    end
    bus_stop();
  endtask

  task automatic read_at(input logic [8:0] a, output logic [7:0] d);
    bit ack;
    bus_start();
    send_byte({4'b1010, 2'b00, a[8], 1'b0}, ack);
    send_byte(a[7:0], ack);
    bus_start();
    send_byte(8'hA1, ack);
    recv_byte(1'b0, d);
    bus_stop();
  endtask

  task automatic t_reset();
    chk("R1 reset releases sda", sda_oe, 0);
  endtask

  task automatic t_byte_write_poll();
    bit ack;
    logic [7:0] d;
    write_bytes(9'h134, 1, 8'h5A);
    bus_start(); send_byte(8'hA0, ack); bus_stop();
    chk("R6 poll while busy nack", ack, 0);
    wait_busy();
    bus_start(); send_byte(8'hA0, ack); bus_stop();
    chk("R6 poll after busy ack", ack, 1);
    read_at(9'h134, d);
    chk("R10 random read", d, 8'h5A);
  endtask

  task automatic t_nomatch();
    bit ack;
    bus_start(); send_byte(8'h92, ack);
    chk("R2 foreign code nack", ack, 0);
    bus_stop();
  endtask

  task automatic t_page_wrap();
    bit ack;
    logic [7:0] d;
    write_bytes(9'h03E, 18, 8'h40);
    wait_busy();
    bus_start();
    send_byte(8'hA0, ack); send_byte(8'h30, ack);
    bus_start(); send_byte(8'hA1, ack);
    chk("R9 read dev ack", ack, 1);
    for (int k = 0; k < 16; k++) begin
      recv_byte(k != 15, d);
      if (k <= 13) chk("R4 page wrap body", d, 8'h42 + k);
      else         chk("R4 page wrap overwrite", d, 8'h50 + (k - 14));
    end
    q_wait(1);
    chk("R9 nack releases sda", sda_oe, 0);
    bus_stop();
    read_at(9'h030, d);
    bus_start(); send_byte(8'hA1, ack); recv_byte(1'b0, d); bus_stop();
    chk("R8 current read after 0x030", d, 8'h43);
  endtask

  task automatic t_top_wrap();
    bit ack;
    logic [7:0] d;
    write_bytes(9'h1FF, 1, 8'hC3);
    wait_busy();
    write_bytes(9'h000, 1, 8'h3C);
    wait_busy();
    bus_start();
    send_byte(8'hA2, ack); send_byte(8'hFF, ack);
    bus_start(); send_byte(8'hA1, ack);
    recv_byte(1'b1, d); chk("R9 seq top byte", d, 8'hC3);
    recv_byte(1'b0, d); chk("R9 seq wraps to 0", d, 8'h3C);
    bus_stop();
    read_at(9'h1FF, d);
    bus_start(); send_byte(8'hA1, ack); recv_byte(1'b0, d); bus_stop();
    chk("R8 current read wraps top to 0", d, 8'h3C);
  endtask

  task automatic t_write_protect();
    bit ack;
    logic [7:0] d;
    wp = 1'b1;
    bus_start();
    send_byte(8'hA2, ack); chk("R7 dev ack under wp", ack, 1);
    send_byte(8'h34, ack); chk("R7 word ack under wp", ack, 1);
    send_byte(8'hEE, ack); chk("R7 data nack under wp", ack, 0);
    bus_stop();
    wp = 1'b0;
    bus_start(); send_byte(8'hA0, ack); bus_stop();
    chk("R7 no busy after wp", ack, 1);
    read_at(9'h134, d);
    chk("R7 array unchanged", d, 8'h5A);
  endtask

  task automatic t_abort();
    bit ack;
    logic [7:0] d;
    bus_start();
    send_byte(8'hA2, ack); send_byte(8'h34, ack);
    send_byte(8'h77, ack); chk("R3 data ack before abort", ack, 1);
    bus_start();
    chk("R1 sda released after restart", sda_oe, 0);
    bus_stop();
    bus_start(); send_byte(8'hA0, ack); bus_stop();
    chk("R5 no commit without stop", ack, 1);
    read_at(9'h134, d);
    chk("R5 data discarded", d, 8'h5A);
    chk("R1 restart abort keeps array", d, 8'h5A);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    t_reset();
    t_byte_write_poll();
    t_nomatch();
    t_page_wrap();
    t_top_wrap();
    t_write_protect();
    t_abort();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule